// File: doc/BRIEF.md
# Snoopy Three-State Coherence Controller

This block keeps the coherence state of a small direct-mapped array of cache lines in a write-back multiprocessor where every cache watches a shared bus. Each line is Invalid, Shared (clean, read-only, possibly held elsewhere) or Dirty (exclusive, read/write, newer than memory). Each line also stores the tag of the block it holds. A block address is split into a low index field that selects the line and a high tag field that is compared with the stored tag.

Two event streams arrive each cycle. The local processor presents a read or write. The block decides hit or miss from the stored state and tag, moves the line, and asks for a bus transaction when other caches must learn of it. The bus side presents transactions snooped from other processors (read miss, write miss, invalidate). These move a matching line and ask for a copy-back when the line holds the only current copy. A snoop always wins. A local event that conflicts with it is refused with a retry pulse and is simply presented again. Bus arbitration and data movement belong to the neighbouring logic.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. The first local read to any address then misses and reports prior state 0.
- R2: A local read that misses places a read miss (bus code 1) carrying the request address on the bus. The line becomes Shared (state code 1) with the new tag.
- R3: A local read hit on a Shared or Dirty line, or a local write hit on a Dirty line, raises no bus request and leaves the state unchanged.
- R4: A local write hit on a Shared line sends an invalidate (bus code 3) for that address. The line becomes Dirty (state code 2).
- R5: A local write miss places a write miss (bus code 2) carrying the request address on the bus. The line becomes Dirty with the new tag.
- R6: A local miss that replaces a Dirty line raises a copy-back of the old block, whose address is the stored tag above the index. The copy-back appears in the same cycle as the bus request.
- R7: A snooped write miss or invalidate whose address matches a Shared line makes the line Invalid, with no copy-back.
- R8: A snooped read miss whose address matches a Dirty line raises a copy-back of that address and makes the line Shared.
- R9: A snooped write miss or invalidate whose address matches a Dirty line raises a copy-back of that address and makes the line Invalid.
- R10: A snoop has no effect when its tag differs from the line's tag, when the line is Invalid, or when it is a read miss to a Shared line.
- R11: When a local event and a snoop select the same line index in one cycle, the snoop is applied. The local event is refused with a retry pulse, raises no other local output and changes no state.
- R12: When an accepted local event would need a copy-back in the same cycle as a snoop copy-back, the local event is retried and the snoop's copy-back is issued.
- R13: All results are registered and last one cycle. A local event and a snoop on different lines are both served in the same cycle. The prior-state output gives the line's state before the accepted event, and every local output is 0 when no event was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loc_valid | input | 1 | Local processor event present |
| loc_wr | input | 1 | Local event is a write (0 = read) |
| loc_addr | input | IDX_W+TAG_W | Local block address: tag above index |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_cmd | input | 2 | Snooped command: 1 read miss, 2 write miss, 3 invalidate |
| snp_addr | input | IDX_W+TAG_W | Snooped block address |
| loc_done | output | 1 | Local event of the previous cycle accepted |
| loc_retry | output | 1 | Local event of the previous cycle refused; present it again |
| loc_hit | output | 1 | Accepted local event hit |
| loc_prev_state | output | 2 | Line state before the accepted event: 0 Invalid, 1 Shared, 2 Dirty |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested command, coded as snp_cmd |
| bus_addr | output | IDX_W+TAG_W | Address of the requested transaction |
| cb_req | output | 1 | Copy-back of a dirty block requested |
| cb_addr | output | IDX_W+TAG_W | Block address to copy back |

## Verification
Every result appears on a registered output one clock edge after the inputs are sampled, and holds for exactly one cycle. The bench drives each event just after a falling edge. It checks every output at the next falling edge, half a cycle after the capturing edge, and then idles a cycle so that no pulse can be mistaken for the next event's result. Effects that leave no direct trace, such as an ignored snoop or a refused local event, are confirmed by a later local access whose hit flag, prior state and bus command reveal the line's state.

// File: rtl/coh_pkg.sv
// Shared encodings for the coherence controller.
// Assumes: state and bus command codes are visible at the ports and must stay fixed.
package coh_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_DRT = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_RDMISS = 2'd1,
        CMD_WRMISS = 2'd2,
        CMD_INVAL  = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/coh_line_array.sv
// Per-line state and tag storage in flops, with one read port per event stream.
// The snoop write port changes state only. The local write port changes state and tag.
// Assumes: the two write ports never name the same line in one cycle, because the
// top refuses the local event in that case.
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [IDX_W-1:0] loc_idx,
    output line_st_e         snp_st,
    output logic [TAG_W-1:0] snp_tag,
    output line_st_e         loc_st,
    output logic [TAG_W-1:0] loc_tag,
    input  logic             snp_we,
    input  line_st_e         snp_nxt,
    input  logic             loc_we,
    input  line_st_e         loc_nxt,
    input  logic [TAG_W-1:0] loc_nxt_tag
);
    localparam int NLINES = 1 << IDX_W;

    line_st_e         st_q  [NLINES];
    logic [TAG_W-1:0] tag_q [NLINES];

    // Read ports: select the addressed line for each stream.
    always_comb begin
        snp_st  = st_q[snp_idx];
        snp_tag = tag_q[snp_idx];
        loc_st  = st_q[loc_idx];
        loc_tag = tag_q[loc_idx];
    end

    // Line update: reset to Invalid, otherwise apply whichever port names the line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (!rst_n) begin
                st_q[i]  <= ST_INV;
                tag_q[i] <= '0;
            end else if (snp_we && snp_idx == IDX_W'(i)) begin
                st_q[i] <= snp_nxt;
            end else if (loc_we && loc_idx == IDX_W'(i)) begin
                st_q[i]  <= loc_nxt;
                tag_q[i] <= loc_nxt_tag;
            end
        end
    end

    // R11
    port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_we && loc_we) |-> (snp_idx != loc_idx));
endmodule

// File: rtl/coh_snoop_eval.sv
// Next state of one line under a snooped transaction from another processor.
// Assumes: the line state and tag given are those of the line the snoop index selects.
module coh_snoop_eval
    import coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             valid,
    input  logic [1:0]       cmd,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         cur_st,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             upd,
    output line_st_e         nxt_st,
    output logic             need_cb
);
    bus_cmd_e c;
    logic     match;

    // Transition: only a live line with the same tag reacts to the snoop.
    always_comb begin
        c       = bus_cmd_e'(cmd);
        match   = valid && (c != CMD_NONE) && (cur_st != ST_INV) && (cur_tag == req_tag);
        upd     = 1'b0;
        nxt_st  = cur_st;
        need_cb = 1'b0;
        if (match) begin
            case (cur_st)
                ST_SHR: begin
                    if (c == CMD_WRMISS || c == CMD_INVAL) begin
                        upd    = 1'b1;
                        nxt_st = ST_INV;
                    end
                end
                ST_DRT: begin
                    upd     = 1'b1;
                    need_cb = 1'b1;
                    nxt_st  = (c == CMD_RDMISS) ? ST_SHR : ST_INV;
                end
                default: begin
                    upd = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/coh_local_eval.sv
// Hit detection and next state of one line under a local read or write.
// Assumes: the caller decides whether the event is accepted. Outputs describe it as if it were.
module coh_local_eval
    import coh_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             wr,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         cur_st,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             hit,
    output logic             upd,
    output line_st_e         nxt_st,
    output bus_cmd_e         cmd,
    output logic             need_cb
);
    // Transition: classify hit or miss, then pick the bus message and the new state.
    always_comb begin
        hit     = (cur_st != ST_INV) && (cur_tag == req_tag);
        upd     = 1'b0;
        nxt_st  = cur_st;
        cmd     = CMD_NONE;
        need_cb = 1'b0;
        if (hit) begin
            if (wr && cur_st == ST_SHR) begin
                upd    = 1'b1;
                nxt_st = ST_DRT;
                cmd    = CMD_INVAL;
            end
        end else begin
            upd     = 1'b1;
            nxt_st  = wr ? ST_DRT : ST_SHR;
            cmd     = wr ? CMD_WRMISS : CMD_RDMISS;
            need_cb = (cur_st == ST_DRT);
        end
    end
endmodule

// File: rtl/snoop_coh_ctrl.sv
// Coherence controller for a direct-mapped array of lines: serves one local event
// and one snooped transaction per cycle and registers all of its requests.
// Assumes: the address is tag above index; a refused local event is presented again
// by the requester; one copy-back port is enough since a snoop copy-back wins it.
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   loc_valid,
    input  logic                   loc_wr,
    input  logic [IDX_W+TAG_W-1:0] loc_addr,
    input  logic                   snp_valid,
    input  logic [1:0]             snp_cmd,
    input  logic [IDX_W+TAG_W-1:0] snp_addr,
    output logic                   loc_done,
    output logic                   loc_retry,
    output logic                   loc_hit,
    output logic [1:0]             loc_prev_state,
    output logic                   bus_req,
    output logic [1:0]             bus_cmd,
    output logic [IDX_W+TAG_W-1:0] bus_addr,
    output logic                   cb_req,
    output logic [IDX_W+TAG_W-1:0] cb_addr
);
    localparam int ADDR_W = IDX_W + TAG_W;

    logic [IDX_W-1:0] l_idx, s_idx;
    logic [TAG_W-1:0] l_tag, s_tag;
    line_st_e         l_st, s_st, l_nxt, s_nxt;
    logic [TAG_W-1:0] l_cur_tag, s_cur_tag;
    logic             l_hit, l_upd, l_cb, s_upd, s_cb;
    bus_cmd_e         l_cmd;
    logic             collide, accept;

    assign l_idx = loc_addr[IDX_W-1:0];
    assign l_tag = loc_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_idx     (s_idx),
        .loc_idx     (l_idx),
        .snp_st      (s_st),
        .snp_tag     (s_cur_tag),
        .loc_st      (l_st),
        .loc_tag     (l_cur_tag),
        .snp_we      (s_upd),
        .snp_nxt     (s_nxt),
        .loc_we      (accept && l_upd),
        .loc_nxt     (l_nxt),
        .loc_nxt_tag (l_tag)
    );

    coh_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
        .valid   (snp_valid),
        .cmd     (snp_cmd),
        .req_tag (s_tag),
        .cur_st  (s_st),
        .cur_tag (s_cur_tag),
        .upd     (s_upd),
        .nxt_st  (s_nxt),
        .need_cb (s_cb)
    );

    coh_local_eval #(.TAG_W(TAG_W)) u_local (
        .wr      (loc_wr),
        .req_tag (l_tag),
        .cur_st  (l_st),
        .cur_tag (l_cur_tag),
        .hit     (l_hit),
        .upd     (l_upd),
        .nxt_st  (l_nxt),
        .cmd     (l_cmd),
        .need_cb (l_cb)
    );

    // Arbitration: the snoop wins a shared line index or the single copy-back port.
    always_comb begin
        collide = loc_valid && snp_valid && ((l_idx == s_idx) || (s_cb && l_cb));
        accept  = loc_valid && !collide;
    end

    // Response registers: one-cycle pulses, local fields zero unless accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_done       <= 1'b0;
            loc_retry      <= 1'b0;
            loc_hit        <= 1'b0;
            loc_prev_state <= 2'd0;
            bus_req        <= 1'b0;
            bus_cmd        <= 2'd0;
            bus_addr       <= '0;
            cb_req         <= 1'b0;
            cb_addr        <= '0;
        end else begin
            loc_done       <= accept;
            loc_retry      <= collide;
            loc_hit        <= accept && l_hit;
            loc_prev_state <= accept ? l_st : ST_INV;
            bus_req        <= accept && (l_cmd != CMD_NONE);
            bus_cmd        <= accept ? l_cmd : CMD_NONE;
            bus_addr       <= (accept && l_cmd != CMD_NONE) ? loc_addr : '0;
            if (s_cb) begin
                cb_req  <= 1'b1;
                cb_addr <= snp_addr;
            end else if (accept && l_cb) begin
                cb_req  <= 1'b1;
                cb_addr <= {l_cur_tag, l_idx};
            end else begin
                cb_req  <= 1'b0;
                cb_addr <= '0;
            end
        end
    end

    // R11
    retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_retry |-> (!loc_done && !bus_req));
    // R4
    inval_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd3) |-> (loc_hit && loc_prev_state == 2'd1));
    // R3
    dirty_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_done && loc_hit && loc_prev_state == 2'd2) |-> !bus_req);
    // R2
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd != 2'd3) |-> (loc_done && !loc_hit));
    // R13
    local_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_done |-> (!loc_hit && loc_prev_state == 2'd0 && !bus_req));
endmodule

// File: tb/sim_snoop_coh_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_coh_ctrl;
    typedef struct packed {
        logic       lv;
        logic       lw;
        logic [8:0] la;
        logic       sv;
        logic [1:0] sc;
        logic [8:0] sa;
        logic       ed;
        logic       er;
        logic       eh;
        logic [1:0] ep;
        logic       eb;
        logic [1:0] ec;
        logic [8:0] ea;
        logic       ecb;
        logic [8:0] eca;
        logic [3:0] req;
    } vec_t;

    localparam logic [8:0] A = 9'h011;  // tag 2, line 1
    localparam logic [8:0] B = 9'h021;  // tag 4, line 1
    localparam logic [8:0] C = 9'h012;  // tag 2, line 2
    localparam logic [8:0] D = 9'h0A2;  // tag 20, line 2
    localparam logic [8:0] E = 9'h013;  // line 3, never filled
    localparam logic [8:0] Z = 9'h000;

    function automatic vec_t mk(int lv, int lw, logic [8:0] la, int sv, int sc,
                                logic [8:0] sa, int ed, int er, int eh, int ep,
                                int eb, int ec, logic [8:0] ea, int ecb,
                                logic [8:0] eca, int req);
        vec_t v;
        v.lv = lv[0];  v.lw = lw[0];  v.la = la;
        v.sv = sv[0];  v.sc = sc[1:0]; v.sa = sa;
        v.ed = ed[0];  v.er = er[0];  v.eh = eh[0];  v.ep = ep[1:0];
        v.eb = eb[0];  v.ec = ec[1:0]; v.ea = ea;
        v.ecb = ecb[0]; v.eca = eca;   v.req = req[3:0];
        return v;
    endfunction

    localparam int NV = 29;
    // Columns: local v/wr/addr, snoop v/cmd/addr | done retry hit prev bus cmd addr cb cbaddr | req
    localparam vec_t VECS [NV] = '{
        mk(1,0,A, 0,0,Z, 1,0,0,0, 1,1,A, 0,Z,  2),  // R2 read miss from Invalid
        mk(1,0,A, 0,0,Z, 1,0,1,1, 0,0,Z, 0,Z,  3),  // R3 read hit Shared
        mk(1,1,A, 0,0,Z, 1,0,1,1, 1,3,A, 0,Z,  4),  // R4 write hit Shared
        mk(1,1,A, 0,0,Z, 1,0,1,2, 0,0,Z, 0,Z,  3),  // R3 write hit Dirty
        mk(1,0,A, 0,0,Z, 1,0,1,2, 0,0,Z, 0,Z,  3),  // R3 read hit Dirty
        mk(0,0,Z, 1,1,A, 0,0,0,0, 0,0,Z, 1,A,  8),  // R8 snoop read miss on Dirty
        mk(1,0,A, 0,0,Z, 1,0,1,1, 0,0,Z, 0,Z,  8),  // R8 line now Shared
        mk(0,0,Z, 1,2,A, 0,0,0,0, 0,0,Z, 0,Z,  7),  // R7 snoop write miss on Shared
        mk(1,0,A, 0,0,Z, 1,0,0,0, 1,1,A, 0,Z,  7),  // R7 line now Invalid
        mk(0,0,Z, 1,2,B, 0,0,0,0, 0,0,Z, 0,Z, 10),  // R10 tag mismatch
        mk(1,1,A, 0,0,Z, 1,0,1,1, 1,3,A, 0,Z, 10),  // R10 line still Shared
        mk(1,0,B, 0,0,Z, 1,0,0,2, 1,1,B, 1,A,  6),  // R6 replace Dirty on read miss
        mk(1,1,C, 0,0,Z, 1,0,0,0, 1,2,C, 0,Z,  5),  // R5 write miss
        mk(0,0,Z, 1,2,C, 0,0,0,0, 0,0,Z, 1,C,  9),  // R9 snoop write miss on Dirty
        mk(1,0,B, 1,3,B, 0,1,0,0, 0,0,Z, 0,Z, 11),  // R11 same line collision
        mk(1,0,B, 0,0,Z, 1,0,0,0, 1,1,B, 0,Z, 11),  // R11 snoop applied, retry served
        mk(1,1,C, 0,0,Z, 1,0,0,0, 1,2,C, 0,Z,  5),  // R5 write miss again
        mk(1,1,A, 1,1,C, 1,0,0,1, 1,2,A, 1,C, 13),  // R13 both served, R8 copy-back
        mk(1,1,C, 0,0,Z, 1,0,1,1, 1,3,C, 0,Z,  4),  // R4 write hit Shared
        mk(1,0,D, 1,2,A, 0,1,0,0, 0,0,Z, 1,A, 12),  // R12 two copy-backs
        mk(1,0,D, 0,0,Z, 1,0,0,2, 1,1,D, 1,C, 12),  // R12 retry served with copy-back
        mk(1,1,D, 0,0,Z, 1,0,1,1, 1,3,D, 0,Z,  4),  // R4
        mk(0,0,Z, 1,3,D, 0,0,0,0, 0,0,Z, 1,D,  9),  // R9 snoop invalidate on Dirty
        mk(1,0,D, 0,0,Z, 1,0,0,0, 1,1,D, 0,Z,  9),  // R9 line now Invalid
        mk(0,0,Z, 1,1,D, 0,0,0,0, 0,0,Z, 0,Z, 10),  // R10 read miss on Shared
        mk(1,0,D, 0,0,Z, 1,0,1,1, 0,0,Z, 0,Z, 10),  // R10 still Shared
        mk(1,1,D, 0,0,Z, 1,0,1,1, 1,3,D, 0,Z,  4),  // R4
        mk(1,1,C, 0,0,Z, 1,0,0,2, 1,2,C, 1,D,  6),  // R6 replace Dirty on write miss
        mk(0,0,Z, 1,2,E, 0,0,0,0, 0,0,Z, 0,Z, 10)   // R10 snoop on Invalid line
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_valid = 1'b0, loc_wr = 1'b0, snp_valid = 1'b0;
    logic [8:0] loc_addr = '0, snp_addr = '0;
    logic [1:0] snp_cmd = '0;
    logic       loc_done, loc_retry, loc_hit, bus_req, cb_req;
    logic [1:0] loc_prev_state, bus_cmd;
    logic [8:0] bus_addr, cb_addr;
    int         n_chk = 0, n_fail = 0;
    bit         ended = 1'b0;

    always #2.5 clk = ~clk;

    snoop_coh_ctrl #(.IDX_W(3), .TAG_W(6)) u0 (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .loc_done(loc_done), .loc_retry(loc_retry), .loc_hit(loc_hit),
        .loc_prev_state(loc_prev_state), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .cb_req(cb_req), .cb_addr(cb_addr)
    );

    function automatic logic [29:0] observed();
        return {loc_done, loc_retry, loc_hit, loc_prev_state, bus_req, bus_cmd,
                bus_addr, cb_req, cb_addr};
    endfunction

    task automatic check(logic [29:0] exp, int req, string what);
        n_chk++;
        if (observed() !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, observed(), exp);
        end
    endtask

    // Drive one event after a falling edge, check at the next falling edge, then idle.
    task automatic step(vec_t v, string what);
        @(negedge clk);
        loc_valid = v.lv; loc_wr = v.lw; loc_addr = v.la;
        snp_valid = v.sv; snp_cmd = v.sc; snp_addr = v.sa;
        @(negedge clk);
        loc_valid = 1'b0; loc_wr = 1'b0; loc_addr = '0;
        snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
        check({v.ed, v.er, v.eh, v.ep, v.eb, v.ec, v.ea, v.ecb, v.eca}, int'(v.req), what);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs idle while reset is held
        check(30'd0, 1, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check(30'd0, 13, "idle after reset");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i], $sformatf("vector %0d", i));
        end

        // R13 pulses last one cycle: nothing remains after the idle cycle
        @(negedge clk);
        check(30'd0, 13, "pulses cleared");

        // R1 reset mid-run returns every line to Invalid
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [8:0] a;
            a = {6'h2, 3'(i)};
            step(mk(1,0,a, 0,0,Z, 1,0,0,0, 1,1,a, 0,Z, 1), $sformatf("R1 line %0d", i));
        end
        finish_run();
    end
endmodule